// File: doc/BRIEF.md
# Three-Port Parallel I/O Register Decoder

This block is the bus-side register logic of a 24-line parallel I/O peripheral. The 24 lines form port A and port B, each 8 bits, and port C, which is split into an upper and a lower nibble. An active-low chip select and a two-bit address choose one of four targets: one of the three ports or a write-only command register. Active-low read and write strobes move bytes between the internal data bus and the chosen target.

A byte written to the command address does one of two things, and bit 7 decides which. With bit 7 set, the byte reprograms the mode and direction of every port. With bit 7 clear, the byte forces one port C bit high or low and leaves the mode configuration alone. The block holds the output latches and drives the per-port output enables. It also exports the decoded mode fields, together with a one-cycle bit-command pulse, so that separate handshake units can use them.

Writes are sampled in the system clock domain. A write takes effect on the clock edge at which the write strobe is first seen high again after being low.

Top module: `par_io_regs`

## Requirements
- R1: With `csN` low, `addr` 0 selects port A, 1 port B, 2 port C and 3 the command register. With `csN` high, no write changes any latch or the configuration.
- R2: While `rst` is high, every output enable is 0 (all ports input), all output latches are 0, both port modes are 0 (simple), and `bitCmdPulse` is 0.
- R3: A write takes effect on the first clock edge at which `wrN` is sampled high after having been sampled low. While `wrN` is held low, nothing changes.
- R4: A read at address 3 returns 8'h00 whatever has been written to the command register.
- R5: A command byte with bit 7 = 1 loads the configuration. Bits 6..5 give `modeA` (00 simple, 01 strobed, 1x bidirectional), bit 4 the port A direction, bit 3 the port C upper direction, bit 2 `modeB`, bit 1 the port B direction and bit 0 the port C lower direction. A direction bit of 1 means input, which drives the matching output enable(s) to 0.
- R6: A command byte with bit 7 = 0 writes value bit 0 (1 set, 0 clear) into the port C latch bit numbered by bits 3..1. On the following cycle, `bitCmdPulse` is high for exactly one cycle, with that number on `bitCmdIdx` and that value on `bitCmdVal`.
- R7: A bit command leaves the mode fields and all direction enables unchanged.
- R8: Any mode command clears the port A, B and C output latches to zero.
- R9: A read of a port, or of a port C nibble, that is set as input returns the live input pins. If it is set as output, the read returns the latch.
- R10: Data written to a port latch appears on that port's output and holds until the next write that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| addr | input | 2 | Target select |
| wrData | input | 8 | Write data from the internal bus |
| rdData | output | 8 | Read data to the internal bus |
| portAIn | input | 8 | Port A pin inputs |
| portBIn | input | 8 | Port B pin inputs |
| portCIn | input | 8 | Port C pin inputs |
| portAOut | output | 8 | Port A output latch |
| portBOut | output | 8 | Port B output latch |
| portCOut | output | 8 | Port C output latch |
| portAOe | output | 1 | Port A output enable |
| portBOe | output | 1 | Port B output enable |
| portCOe | output | 8 | Port C per-bit output enables (nibble-wide groups) |
| modeA | output | 2 | Decoded port A mode |
| modeB | output | 1 | Decoded port B mode |
| bitCmdPulse | output | 1 | One-cycle pulse after a bit command |
| bitCmdIdx | output | 3 | Port C bit number of the last bit command |
| bitCmdVal | output | 1 | Value of the last bit command |

## Verification
The assertions assume that `addr`, `wrData` and `csN` stay stable from the falling edge of `wrN` until after the clock edge that sees it rise. They also assume that read and write strobes are never low together. The bench drives every access through a single write or read task that holds the select lines for two cycles around the strobe, changes inputs only on falling clock edges, and never overlaps strobes. Under those conditions, exactly one write strobe fires per access, and the configuration is stable across each bit command.

// File: rtl/par_io_pkg.sv
package par_io_pkg;

  localparam int DATA_W = 8;
  localparam int NIB_W  = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef struct packed {
    logic [1:0] modeA;
    logic       dirAIn;
    logic       dirCuIn;
    logic       modeB;
    logic       dirBIn;
    logic       dirClIn;
  } modeCfg_t;

  localparam modeCfg_t CFG_RESET = '{modeA: 2'b00, dirAIn: 1'b1, dirCuIn: 1'b1,
                                     modeB: 1'b0, dirBIn: 1'b1, dirClIn: 1'b1};

  typedef struct packed {
    logic              wrA;
    logic              wrB;
    logic              wrC;
    logic              wrMode;
    logic              wrBit;
    logic [DATA_W-1:0] data;
  } regStrobes_t;

endpackage

// File: rtl/par_io_ctrl.sv
module par_io_ctrl
  import par_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output regStrobes_t       strobes,
  output modeCfg_t          cfg
);

  logic wrNPrev;
  logic wrRise;

  always_ff @(posedge clk) begin
    if (rst) wrNPrev <= 1'b1;
    else     wrNPrev <= wrN;
  end

  assign wrRise = wrN && !wrNPrev && !csN;

  always_comb begin
    strobes        = '0;
    strobes.data   = wrData;
    if (wrRise) begin
      unique case (addr)
        2'd0: strobes.wrA = 1'b1;
        2'd1: strobes.wrB = 1'b1;
        2'd2: strobes.wrC = 1'b1;
        2'd3: begin
          strobes.wrMode = wrData[DATA_W-1];
          strobes.wrBit  = !wrData[DATA_W-1];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 cfg <= CFG_RESET;
    else if (strobes.wrMode) cfg <= modeCfg_t'(wrData[6:0]);
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.wrA, strobes.wrB, strobes.wrC, strobes.wrMode, strobes.wrBit})); // R1

  AST_NO_SELECT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    csN |-> !(strobes.wrA || strobes.wrB || strobes.wrC || strobes.wrMode || strobes.wrBit)); // R1

  AST_BIT_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    strobes.wrBit |=> $stable(cfg)); // R7

  AST_LOW_STROBE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !wrN |-> !(strobes.wrA || strobes.wrB || strobes.wrC || strobes.wrMode || strobes.wrBit)); // R3

endmodule

// File: rtl/par_io_datapath.sv
module par_io_datapath
  import par_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  regStrobes_t       strobes,
  input  modeCfg_t          cfg,
  input  logic              csN,
  input  logic              rdN,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] portAIn,
  input  logic [DATA_W-1:0] portBIn,
  input  logic [DATA_W-1:0] portCIn,
  output logic [DATA_W-1:0] latchA,
  output logic [DATA_W-1:0] latchB,
  output logic [DATA_W-1:0] latchC,
  output logic [DATA_W-1:0] rdData,
  output logic              bitPulse,
  output logic [IDX_W-1:0]  bitIdx,
  output logic              bitVal
);

  logic [IDX_W-1:0]  cmdIdx;
  logic              cmdVal;
  logic [DATA_W-1:0] readC;
  logic [1:0]        nibIsIn;

  assign cmdIdx  = strobes.data[IDX_W:1];
  assign cmdVal  = strobes.data[0];
  assign nibIsIn = {cfg.dirCuIn, cfg.dirClIn};

  always_ff @(posedge clk) begin
    if (rst) begin
      latchA <= '0;
      latchB <= '0;
      latchC <= '0;
    end else if (strobes.wrMode) begin
      latchA <= '0;
      latchB <= '0;
      latchC <= '0;
    end else begin
      if (strobes.wrA) latchA <= strobes.data;
      if (strobes.wrB) latchB <= strobes.data;
      if (strobes.wrC) latchC <= strobes.data;
      if (strobes.wrBit) latchC[cmdIdx] <= cmdVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitPulse <= 1'b0;
      bitIdx   <= '0;
      bitVal   <= 1'b0;
    end else begin
      bitPulse <= strobes.wrBit;
      if (strobes.wrBit) begin
        bitIdx <= cmdIdx;
        bitVal <= cmdVal;
      end
    end
  end

  for (genvar n = 0; n < 2; n++) begin : gNibRead
    assign readC[n*NIB_W +: NIB_W] = nibIsIn[n] ? portCIn[n*NIB_W +: NIB_W]
                                                : latchC[n*NIB_W +: NIB_W];
  end

  always_comb begin
    rdData = '0;
    if (!csN && !rdN) begin
      unique case (addr)
        2'd0: rdData = cfg.dirAIn ? portAIn : latchA;
        2'd1: rdData = cfg.dirBIn ? portBIn : latchB;
        2'd2: rdData = readC;
        2'd3: rdData = '0;
      endcase
    end
  end

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    strobes.wrMode |=> (latchA == '0 && latchB == '0 && latchC == '0)); // R8

  AST_BIT_APPLIED: assert property (@(posedge clk) disable iff (rst)
    strobes.wrBit |=> (latchC[bitIdx] == bitVal && bitPulse)); // R6

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bitPulse |=> !bitPulse); // R6

  AST_CMD_UNREADABLE: assert property (@(posedge clk) disable iff (rst)
    (!csN && !rdN && addr == 2'd3) |-> rdData == '0); // R4

endmodule

// File: rtl/par_io_regs.sv
module par_io_regs
  import par_io_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] portAIn,
  input  logic [7:0] portBIn,
  input  logic [7:0] portCIn,
  output logic [7:0] portAOut,
  output logic [7:0] portBOut,
  output logic [7:0] portCOut,
  output logic       portAOe,
  output logic       portBOe,
  output logic [7:0] portCOe,
  output logic [1:0] modeA,
  output logic       modeB,
  output logic       bitCmdPulse,
  output logic [2:0] bitCmdIdx,
  output logic       bitCmdVal
);

  regStrobes_t strobes;
  modeCfg_t    cfg;

  par_io_ctrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .csN     (csN),
    .wrN     (wrN),
    .addr    (addr),
    .wrData  (wrData),
    .strobes (strobes),
    .cfg     (cfg)
  );

  par_io_datapath uData (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .cfg      (cfg),
    .csN      (csN),
    .rdN      (rdN),
    .addr     (addr),
    .portAIn  (portAIn),
    .portBIn  (portBIn),
    .portCIn  (portCIn),
    .latchA   (portAOut),
    .latchB   (portBOut),
    .latchC   (portCOut),
    .rdData   (rdData),
    .bitPulse (bitCmdPulse),
    .bitIdx   (bitCmdIdx),
    .bitVal   (bitCmdVal)
  );

  assign portAOe = !cfg.dirAIn;
  assign portBOe = !cfg.dirBIn;
  assign portCOe = {{NIB_W{!cfg.dirCuIn}}, {NIB_W{!cfg.dirClIn}}};
  assign modeA   = cfg.modeA;
  assign modeB   = cfg.modeB;

endmodule

// File: tb/tb_par_io_regs.sv
`timescale 1ns/1ps
module tb_par_io_regs;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       csN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic [7:0] portAIn = 8'h00, portBIn = 8'h00, portCIn = 8'h00;
  logic [7:0] portAOut, portBOut, portCOut, portCOe;
  logic       portAOe, portBOe, modeB, bitCmdPulse, bitCmdVal;
  logic [1:0] modeA;
  logic [2:0] bitCmdIdx;

  int checks = 0;
  int fails  = 0;
  logic       pulseFirst, pulseSecond;
  logic [2:0] seenIdx;
  logic       seenVal;

  always #5 clk = ~clk;

  par_io_regs dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    csN = !sel; addr = a; wrData = d; wrN = 1'b0;
    repeat (2) @(negedge clk);
    wrN = 1'b1;
    @(negedge clk);
    pulseFirst = bitCmdPulse; seenIdx = bitCmdIdx; seenVal = bitCmdVal;
    @(negedge clk);
    pulseSecond = bitCmdPulse;
    csN = 1'b1;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; addr = a; rdN = 1'b0;
    #1 d = rdData;
    @(negedge clk);
    rdN = 1'b1; csN = 1'b1;
  endtask

  task automatic testReset();
    check("R2 portAOe", portAOe, 0);
    check("R2 portBOe", portBOe, 0);
    check("R2 portCOe", portCOe, 8'h00);
    check("R2 latches", {portAOut, portBOut, portCOut}, 0);
    check("R2 modes", {modeA, modeB}, 0);
    check("R2 pulse", bitCmdPulse, 0);
  endtask

  task automatic testModeLoad();
    busWrite(2'd3, 8'b1_01_0_1_1_0_0); // A strobed, A out, CU in, B strobed, B out, CL out
    check("R5 modeA", modeA, 2'b01);
    check("R5 modeB", modeB, 1);
    check("R5 portAOe", portAOe, 1);
    check("R5 portBOe", portBOe, 1);
    check("R5 portCOe", portCOe, 8'h0F);
    busWrite(2'd3, 8'b1_10_1_0_0_1_1); // A bidir, A in, CU out, B simple, B in, CL in
    check("R5 modeA bidir", modeA, 2'b10);
    check("R5 dirs", {portAOe, portBOe, portCOe}, {1'b0, 1'b0, 8'hF0});
  endtask

  task automatic testStrobeTiming();
    busWrite(2'd3, 8'h80); // all simple, all outputs
    @(negedge clk);
    csN = 1'b0; addr = 2'd0; wrData = 8'h5A; wrN = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 held low no change", portAOut, 8'h00);
    wrN = 1'b1;
    @(negedge clk);
    check("R3 rise applies", portAOut, 8'h5A);
    csN = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 latch holds", portAOut, 8'h5A);
  endtask

  task automatic testDecode();
    logic [7:0] r;
    busWrite(2'd1, 8'hC3);
    busWrite(2'd2, 8'h96);
    check("R1 port B", portBOut, 8'hC3);
    check("R1 port C", portCOut, 8'h96);
    check("R1 port A untouched", portAOut, 8'h5A);
    busWrite(2'd0, 8'hFF, 1'b0);
    busWrite(2'd3, 8'h9B, 1'b0);
    check("R1 deselected A", portAOut, 8'h5A);
    check("R1 deselected cfg", {modeA, portAOe, portCOe}, {2'b00, 1'b1, 8'hFF});
    busRead(2'd0, r); check("R9 output A reads latch", r, 8'h5A);
    busRead(2'd3, r); check("R4 cmd read zero", r, 8'h00);
  endtask

  task automatic testBitCmd();
    busWrite(2'd3, 8'h0F); // set bit 7
    check("R6 set bit7", portCOut, 8'h96 | 8'h80);
    check("R6 pulse", pulseFirst, 1);
    check("R6 pulse one cycle", pulseSecond, 0);
    check("R6 idx val", {seenIdx, seenVal}, {3'd7, 1'b1});
    busWrite(2'd3, 8'h04); // clear bit 2
    check("R6 clear bit2", portCOut, 8'h92);
    check("R6 idx val clr", {seenIdx, seenVal}, {3'd2, 1'b0});
    check("R7 cfg kept", {modeA, modeB, portAOe, portBOe, portCOe}, {2'b00, 1'b0, 1'b1, 1'b1, 8'hFF});
    check("R7 port A kept", portAOut, 8'h5A);
  endtask

  task automatic testModeClears();
    logic [7:0] r;
    busWrite(2'd3, 8'b1_00_1_0_0_0_1); // A in, CU out, B out, CL in
    check("R8 latches cleared", {portAOut, portBOut, portCOut}, 0);
    busWrite(2'd2, 8'hA5);
    portAIn = 8'h3C; portCIn = 8'h7E; portBIn = 8'h11;
    busRead(2'd0, r); check("R9 input A live", r, 8'h3C);
    busRead(2'd1, r); check("R9 output B latch", r, 8'h00);
    busRead(2'd2, r); check("R9 C nibbles", r, 8'hAE);
    portAIn = 8'hC1;
    busRead(2'd0, r); check("R9 input A unlatched", r, 8'hC1);
    busRead(2'd3, r); check("R4 cmd read after mode", r, 8'h00);
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst = 1'b0;
    @(negedge clk);
    testModeLoad();
    testStrobeTiming();
    testDecode();
    testBitCmd();
    testModeClears();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule